// File: doc/BRIEF.md
# Decimating Bandpass Demodulator for a Resolver Channel

The block receives signed Q15 samples of one amplitude-modulated resolver winding. The samples arrive at eight times the excitation frequency. Each accepted sample is halved, which gives 6 dB of headroom, and is written into a 32-entry circular history. A symmetric 17-tap bandpass FIR is centred on the excitation frequency and passes the excitation frequency plus or minus half of it. The filter is evaluated for only one input out of every eight. This skipped evaluation is both the decimation and a synchronous demodulation: the result is the baseband envelope, sampled once per excitation period.

A phase-offset parameter chooses which of the eight input slots closes the filtered window, so the window can be aligned with the carrier peak. Symmetric tap pairs are summed before they are multiplied. The filter therefore takes nine multiply-accumulates, run one per cycle into a wide accumulator. The accumulator is rounded and saturated back to Q15 and presented with a one-cycle valid strobe. A system uses two instances, one for the sine winding and one for the cosine winding. Their outputs feed an angle extractor.

Top module: `res_bpf_decim`

## Requirements
- R1: While rst_ni is low, and after it is released, flt_o is 0 and flt_vld_o is 0. Reset also clears every history entry, so the first window after a reset sees zeros in every slot that has not yet been written.
- R2: Each accepted sample is stored as the sample shifted right by one bit with sign extension, which rounds toward minus infinity. For example, an input of -7 is stored as -4.
- R3: Count the accepted samples from reset, starting at 0. A result is produced only for a sample whose count modulo 8 equals PHASE_OFS. No result is produced for any other sample.
- R4: For a triggering sample n, with stored values w, the result is the sum over j = 0..7 of COEFS[j]·(w[n−j] + w[n−16+j]), plus COEFS[8]·w[n−8]. COEFS[j] is field j of the packed COEFS parameter, and field 8 is the centre tap.
- R5: Taps j and 16−j share one coefficient, so one result takes exactly nine accumulate steps.
- R6: The Q30 sum is rounded to Q15 by adding 2^14 and then shifting right arithmetically by 15, so exact halves round toward plus infinity. A sum of +37.5 LSB gives 38, and −37.5 LSB gives −37.
- R7: A rounded result above 32767 is output as 32767, and one below −32768 is output as −32768.
- R8: flt_vld_o goes high for exactly one cycle, 10 clock edges after the edge that accepts the triggering sample. flt_o holds its value until the next result.
- R9: The history index wraps modulo 32. Results stay correct for windows that cross the wrap point.
- R10: Strobes on smp_vld_i must be separated by at least one idle cycle. Idle gaps of any length are allowed.
- R11: An input carrier at one eighth of the sample rate, with constant amplitude, gives results that become constant once the window holds carrier samples in every slot. The sign of the result follows the sign of the amplitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_vld_i | input | 1 | Sample strobe |
| smp_i | input | DATA_W | Signed Q15 input sample |
| flt_vld_o | output | 1 | One-cycle result strobe |
| flt_o | output | DATA_W | Signed Q15 demodulated result |

## Verification
The assertions check the following on every cycle:
- the spacing of input strobes, and that a new evaluation never starts while one is running;
- that triggers fall exactly on the configured slot and then every eighth sample after it;
- that the history pointer advances by one per sample and that each stored value is the halved input;
- that the result strobe is a single pulse and that the held result does not change.

Only the bench's scenarios can show whether the filtered values are right. These scenarios are carriers of both signs, a DC input, alternating and ramped inputs, and windows that cross the wrap point. They also cover the rounding of exact halves, saturation in both directions, the halving of a negative odd input, and the clearing of the history by a reset issued in the middle of a run.

// File: rtl/bpf_pkg.sv
package bpf_pkg;
  localparam int DEF_DATA_W = 16;
  localparam int DEF_COEF_W = 16;
  localparam int DEF_TAPS   = 17;
  localparam int DEF_DECIM  = 8;
  localparam int DEF_DEPTH  = 32;
  localparam int DEF_ACC_W  = 40;

  // field j = tap j = tap 16-j, field 8 = centre
  localparam logic [8:0][15:0] DEF_COEFS = {
    16'sd15000, 16'sd12000, 16'sd0, -16'sd9000, -16'sd10000,
    -16'sd6000, 16'sd0, 16'sd2400, 16'sd600
  };
endpackage

// File: rtl/bpf_ring.sv
module bpf_ring #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic signed [DATA_W-1:0] wr_data_i,
  output logic [AW-1:0]            wr_ptr_o,
  input  logic [AW-1:0]            rd_a_addr_i,
  input  logic [AW-1:0]            rd_b_addr_i,
  output logic signed [DATA_W-1:0] rd_a_o,
  output logic signed [DATA_W-1:0] rd_b_o
);
  logic signed [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]            ptr_q;
  logic signed [DATA_W-1:0] halved;

  assign halved = wr_data_i >>> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[ptr_q] <= halved;
      ptr_q        <= ptr_q + 1'b1;
    end
  end

  assign wr_ptr_o = ptr_q;
  assign rd_a_o   = mem_q[rd_a_addr_i];
  assign rd_b_o   = mem_q[rd_b_addr_i];

  p_ptr_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ptr_q == AW'($past(ptr_q) + 1'b1));

  p_store_half_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mem_q[$past(ptr_q)] == ($past(wr_data_i) >>> 1));
endmodule

// File: rtl/bpf_phase_ctl.sv
module bpf_phase_ctl #(
  parameter int DECIM     = 8,
  parameter int PHASE_OFS = 0,
  localparam int PW       = (DECIM > 1) ? $clog2(DECIM) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smp_vld_i,
  output logic trig_o
);
  logic [PW-1:0] phase_q;

  generate
    if ((1 << PW) == DECIM) begin : g_pow2
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        phase_q <= '0;
        else if (smp_vld_i) phase_q <= phase_q + 1'b1;
      end
    end else begin : g_mod
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        phase_q <= '0;
        else if (smp_vld_i) phase_q <= (phase_q == PW'(DECIM - 1)) ? '0 : phase_q + 1'b1;
      end
    end
  endgenerate

  assign trig_o = smp_vld_i && (phase_q == PW'(PHASE_OFS));

  // checker: samples since reset / since last trigger
  logic [PW:0] since_q;
  logic        seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else if (smp_vld_i) begin
      if (trig_o) begin
        since_q <= '0;
        seen_q  <= 1'b1;
      end else begin
        since_q <= since_q + 1'b1;
      end
    end
  end

  p_decim_slot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> (since_q == (seen_q ? (PW+1)'(DECIM - 1) : (PW+1)'(PHASE_OFS))));
endmodule

// File: rtl/bpf_mac_seq.sv
module bpf_mac_seq #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int HALF   = 8,
  parameter int AW     = 5,
  parameter int ACC_W  = 40,
  parameter logic [HALF:0][COEF_W-1:0] COEFS = '0,
  localparam int SW     = $clog2(HALF + 1),
  localparam int OP_W   = DATA_W + 1,
  localparam int PROD_W = COEF_W + OP_W,
  localparam int FRAC   = COEF_W - 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [AW-1:0]            base_i,
  output logic [AW-1:0]            rd_a_addr_o,
  output logic [AW-1:0]            rd_b_addr_o,
  input  logic signed [DATA_W-1:0] rd_a_i,
  input  logic signed [DATA_W-1:0] rd_b_i,
  output logic signed [DATA_W-1:0] res_o,
  output logic                     res_vld_o
);
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((longint'(1) <<< (DATA_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - 1;
  localparam logic signed [ACC_W-1:0] RND    = ACC_W'(longint'(1) <<< (FRAC - 1));

  logic                     busy_q, done_q;
  logic [SW-1:0]            step_q;
  logic [AW-1:0]            base_q;
  logic signed [ACC_W-1:0]  acc_q;
  logic signed [OP_W-1:0]   op;
  logic signed [COEF_W-1:0] coef;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  rnd, shf, res_n;
  logic                     last_step;

  assign last_step   = (step_q == SW'(HALF));
  assign rd_a_addr_o = base_q - AW'(step_q);
  assign rd_b_addr_o = base_q - AW'(2 * HALF) + AW'(step_q);

  // centre tap has no partner
  assign op   = last_step ? OP_W'(rd_a_i) : OP_W'(rd_a_i) + OP_W'(rd_b_i);
  assign coef = $signed(COEFS[step_q]);
  assign prod = coef * op;

  assign rnd   = acc_q + RND;
  assign shf   = rnd >>> FRAC;
  assign res_n = (shf > SAT_HI) ? SAT_HI : ((shf < SAT_LO) ? SAT_LO : shf);

  logic unused_hi;
  assign unused_hi = ^res_n[ACC_W-1:DATA_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      step_q    <= '0;
      base_q    <= '0;
      acc_q     <= '0;
      res_o     <= '0;
      res_vld_o <= 1'b0;
    end else begin
      res_vld_o <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        step_q <= '0;
        base_q <= base_i;
        acc_q  <= '0;
      end else if (busy_q) begin
        acc_q <= acc_q + ACC_W'(prod);
        if (last_step) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end
      if (done_q) begin
        done_q    <= 1'b0;
        res_o     <= res_n[DATA_W-1:0];
        res_vld_o <= 1'b1;
      end
    end
  end

  p_no_overlap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q && !done_q);

  p_nine_steps_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> step_q <= SW'(HALF));

  p_done_follows_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(busy_q) && $past(step_q) == SW'(HALF));

  p_vld_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_vld_o |=> !res_vld_o);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_vld_o |-> $stable(res_o));
endmodule

// File: rtl/res_bpf_decim.sv
module res_bpf_decim #(
  parameter int DATA_W    = bpf_pkg::DEF_DATA_W,
  parameter int COEF_W    = bpf_pkg::DEF_COEF_W,
  parameter int TAPS      = bpf_pkg::DEF_TAPS,
  parameter int DECIM     = bpf_pkg::DEF_DECIM,
  parameter int DEPTH     = bpf_pkg::DEF_DEPTH,
  parameter int ACC_W     = bpf_pkg::DEF_ACC_W,
  parameter int PHASE_OFS = 0,
  localparam int HALF     = (TAPS - 1) / 2,
  localparam int AW       = $clog2(DEPTH),
  parameter logic [HALF:0][COEF_W-1:0] COEFS = bpf_pkg::DEF_COEFS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_vld_i,
  input  logic [DATA_W-1:0] smp_i,
  output logic              flt_vld_o,
  output logic [DATA_W-1:0] flt_o
);
  logic                     trig;
  logic [AW-1:0]            wr_ptr, rd_a_addr, rd_b_addr;
  logic signed [DATA_W-1:0] rd_a, rd_b, res;

  bpf_phase_ctl #(.DECIM(DECIM), .PHASE_OFS(PHASE_OFS)) i_phase (
    .clk_i, .rst_ni, .smp_vld_i, .trig_o(trig)
  );

  bpf_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_ring (
    .clk_i, .rst_ni,
    .wr_en_i(smp_vld_i), .wr_data_i($signed(smp_i)), .wr_ptr_o(wr_ptr),
    .rd_a_addr_i(rd_a_addr), .rd_b_addr_i(rd_b_addr),
    .rd_a_o(rd_a), .rd_b_o(rd_b)
  );

  bpf_mac_seq #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .HALF(HALF), .AW(AW),
    .ACC_W(ACC_W), .COEFS(COEFS)
  ) i_mac (
    .clk_i, .rst_ni,
    .start_i(trig), .base_i(wr_ptr),
    .rd_a_addr_o(rd_a_addr), .rd_b_addr_o(rd_b_addr),
    .rd_a_i(rd_a), .rd_b_i(rd_b),
    .res_o(res), .res_vld_o(flt_vld_o)
  );

  assign flt_o = res;

  p_strobe_gap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_vld_i |=> !smp_vld_i);

  p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !flt_vld_o);
endmodule

// File: tb/test_res_bpf_decim.sv
module test_res_bpf_decim;
  localparam int OFS = 3;
  localparam logic [8:0][15:0] TB_COEFS = {
    16'sd15000, 16'sd12000, 16'sd0, -16'sd9000, -16'sd10000,
    -16'sd6000, 16'sd0, 16'sd2400, 16'sd600
  };
  localparam int CF [9] = '{600, 2400, 0, -6000, -10000, -9000, 0, 12000, 15000};
  localparam int COS8 [8] = '{1000, 707, 0, -707, -1000, -707, 0, 707};

  // kind: 0 dc, 1 carrier, 2 alternating, 3 ramp
  typedef struct packed { int kind; int amp; int nsmp; int gap; } vec_t;
  localparam vec_t VEC [6] = '{
    '{1,   8000, 40, 1},
    '{1,  32000, 40, 2},
    '{1, -32000, 40, 1},
    '{0,  12000, 24, 3},
    '{2,  20000, 32, 1},
    '{3,      0, 48, 1}
  };

  logic clk = 0, rst_ni = 0, smp_vld = 0;
  logic [15:0] smp = '0;
  logic flt_vld;
  logic [15:0] flt;

  always #4 clk = ~clk;

  res_bpf_decim #(.PHASE_OFS(OFS), .COEFS(TB_COEFS)) i_res_bpf_decim (
    .clk_i(clk), .rst_ni(rst_ni), .smp_vld_i(smp_vld), .smp_i(smp),
    .flt_vld_o(flt_vld), .flt_o(flt)
  );

  int checks = 0, fails = 0;
  int cyc = 0, scnt = 0, pushed = 0, due = 0;
  bit pend = 0, done = 0;
  longint hist [0:4095];
  logic [15:0] exp_v = '0, last = '0;

  task automatic chk(bit ok, string req, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic longint wv(int i);
    return (i < 0) ? 0 : hist[i];
  endfunction

  function automatic logic [15:0] model(int n);
    longint s = 0, r;
    for (int j = 0; j < 8; j++) s += CF[j] * (wv(n - j) + wv(n - 16 + j));
    s += CF[8] * wv(n - 8);
    r = (s + 16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return 16'(r);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_ni) begin
      scnt = 0; pend = 0;
    end else if (smp_vld) begin
      hist[scnt] = longint'($signed(smp)) >>> 1;
      if (scnt % 8 == OFS) begin
        exp_v = model(scnt); pend = 1; due = cyc + 10;
      end
      scnt++;
    end
  end

  always @(negedge clk) begin
    if (!rst_ni) last = '0;
    else if (flt_vld) begin
      chk(pend && due == cyc, "R3/R8 strobe timing", cyc, due);
      chk(flt == exp_v, "R4/R9/R11 value", $signed(flt), $signed(exp_v));
      pend = 0; last = flt;
    end else begin
      if (pend && cyc > due) chk(0, "R3 missing result", cyc, due);
      chk(flt == last, "R8 hold", $signed(flt), $signed(last));
    end
  end

  task automatic push(logic [15:0] v, int gap);
    @(negedge clk); smp_vld = 1; smp = v;
    @(negedge clk); smp_vld = 0;
    repeat (gap) @(negedge clk);
    pushed++;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 0;
    repeat (2) @(negedge clk);
    chk(flt == 0, "R1 reset data", $signed(flt), 0);
    chk(flt_vld == 0, "R1 reset strobe", flt_vld, 0);
    rst_ni = 1; pushed = 0;
  endtask

  function automatic logic [15:0] gen(int kind, int amp, int k);
    case (kind)
      0: return 16'(amp);
      1: return 16'(amp * COS8[((pushed - OFS) % 8 + 8) % 8] / 1000);
      2: return 16'((k % 2) ? -amp : amp);
      default: return 16'(k * 700 - 16000);
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(flt == 0 && flt_vld == 0, "R1 reset state", flt, 0);
    rst_ni = 1;
    // table walk
    for (int v = 0; v < 6; v++) begin
      for (int k = 0; k < VEC[v].nsmp; k++) push(gen(VEC[v].kind, VEC[v].amp, k), VEC[v].gap);
      repeat (12) @(negedge clk);
      if (VEC[v].kind == 1 && VEC[v].amp == 32000)
        chk(flt == 16'h7FFF, "R7 positive saturation", $signed(flt), 32767);
      if (VEC[v].kind == 1 && VEC[v].amp == -32000)
        chk(flt == 16'h8000, "R7 negative saturation", $signed(flt), -32768);
    end
    // mid-run reset clears history, then half rounds up
    do_reset();
    for (int k = 0; k < 3; k++) push(16'd0, 1);
    push(16'd4096, 1);
    repeat (12) @(negedge clk);
    chk($signed(flt) == 38, "R1/R6 +37.5 rounds to 38", $signed(flt), 38);
    do_reset();
    for (int k = 0; k < 3; k++) push(16'd0, 1);
    push(-16'sd4096, 2);
    repeat (12) @(negedge clk);
    chk($signed(flt) == -37, "R6 -37.5 rounds to -37", $signed(flt), -37);
    // floor halving: -7 -> -4 at centre tap gives -2 (truncation would give -1)
    do_reset();
    for (int k = 0; k < 3; k++) push(16'd0, 1);
    push(-16'sd7, 1);
    for (int k = 0; k < 8; k++) push(16'd0, 1);
    repeat (12) @(negedge clk);
    chk($signed(flt) == -2, "R2 floor halving", $signed(flt), -2);
    repeat (4) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule